// File: doc/BRIEF.md
# Prescaled Dual Timer Unit

This block holds two down-counting timers. Each timer has its own prescaler, and both prescalers run on the system clock. The prescaler decides how many system clocks make up one step of the main counter. The general-purpose channel has a 16-bit prescaler. The real-time-clock channel has an 8-bit prescaler. Each channel can run in one-shot mode or periodic mode. A channel raises its interrupt line when its programmed delay has run out.

Software reaches the block through a plain register port. Writes take effect on the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`. The register map is:

- 0: GPT prescaler reload
- 1: GPT counter reload
- 2: GPT control
- 3: RTC prescaler reload
- 4: RTC counter reload
- 5: RTC control
- 6: system control
- 8: live GPT prescaler
- 9: live GPT counter
- 10: live RTC prescaler
- 11: live RTC counter

Every other address reads as zero. Both control registers use the same bits: bit 0 is enable, bit 1 selects periodic mode, and bit 2 is a load strobe that is not stored. System control bit 0 allows the external debug pin to freeze counting.

The real-time-clock channel puts its step tick on a dedicated output. When both channels expire in the same cycle, the real-time-clock interrupt is reported first.

Top module: `dtu_top`

## Requirements
- R1: After reset, every reload, control and live register reads 0, and `irq_gpt`, `irq_rtc` and `rtc_tick` are low.
- R2: The live prescaler counts down once per clock while the channel is enabled. When it reaches 0 it reloads and moves the counter down by one. With prescaler reload P and counter reload C, the first interrupt goes high (C+1)(P+1) clock edges after the edge that loaded and enabled the channel.
- R3: Only the low 16 bits of a GPT prescaler write are kept, and only the low 8 bits of an RTC prescaler write are kept.
- R4: In periodic mode (control bit 1 = 1), the counter reloads from its reload register when it underflows. Interrupts then repeat every (C+1)(P+1) edges until the enable bit is cleared.
- R5: In one-shot mode (control bit 1 = 0), an underflow clears control bit 0. After that, no further interrupt occurs.
- R6: Writing a control register with bit 2 set copies both reload registers into the live prescaler and live counter. The live values read back at addresses 8 to 11.
- R7: Each underflow produces a single-cycle interrupt pulse, one cycle after the underflow. No pulse appears without an underflow.
- R8: When both channels underflow in the same cycle, `irq_rtc` pulses first and `irq_gpt` pulses in the following cycle. The two lines are never high together.
- R9: While system control bit 0 and `dbg_pin` are both 1, every prescaler and counter holds its value, so a frozen span of F clocks delays the interrupt by F. Either signal alone does not freeze counting.
- R10: `rtc_tick` pulses once for each RTC counter step, so a one-shot RTC run with counter reload C gives C+1 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Combinational read data |
| dbg_pin | input | 1 | External debug request |
| rtc_tick | output | 1 | One-cycle pulse per RTC counter step |
| irq_rtc | output | 1 | RTC interrupt pulse (higher priority) |
| irq_gpt | output | 1 | GPT interrupt pulse (lower priority) |

## Verification
The hardest case to reach is two underflows landing on the same cycle. The channels are programmed through separate writes, so they can never be started on the same edge. The bench sets the debug-freeze allow bit, holds `dbg_pin` high, and loads both channels with equal reloads. It then reads the frozen live values and releases the pin. Both channels then start on the same edge, and their expiry collides exactly (C+1)(P+1) edges later.

// File: rtl/dtu_pkg.sv
package dtu_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_GPT_PRE  = 4'd0,
    A_GPT_CNT  = 4'd1,
    A_GPT_CTL  = 4'd2,
    A_RTC_PRE  = 4'd3,
    A_RTC_CNT  = 4'd4,
    A_RTC_CTL  = 4'd5,
    A_SYS_CTL  = 4'd6,
    A_GPT_PLIV = 4'd8,
    A_GPT_CLIV = 4'd9,
    A_RTC_PLIV = 4'd10,
    A_RTC_CLIV = 4'd11
  } reg_addr_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_PER  = 1;
  localparam int CTL_LOAD = 2;
  localparam int CTL_W    = 3;
endpackage

// File: rtl/dtu_prescaler.sv
module dtu_prescaler #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] reload,
  output logic [W-1:0] value,
  output logic         step
);
  localparam logic [W-1:0] ZERO = '0;

  assign step = run && (value == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= ZERO;
    end else if (load) begin
      value <= reload;
    end else if (run) begin
      value <= (value == ZERO) ? reload : value - 1'b1;
    end
  end
endmodule

// File: rtl/dtu_channel.sv
module dtu_channel #(
  parameter int PRE_W = 16,
  parameter int CNT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      freeze,
  input  logic                      ctl_we,
  input  logic [dtu_pkg::CTL_W-1:0] ctl_wdata,
  input  logic [PRE_W-1:0]          pre_rld,
  input  logic [CNT_W-1:0]          cnt_rld,
  output logic                      en,
  output logic                      periodic,
  output logic [PRE_W-1:0]          pre_live,
  output logic [CNT_W-1:0]          cnt_live,
  output logic                      step,
  output logic                      underflow
);
  import dtu_pkg::*;
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic run;
  logic load;

  assign run       = en && !freeze;
  assign load      = ctl_we && ctl_wdata[CTL_LOAD];
  assign underflow = step && (cnt_live == CNT_ZERO);

  dtu_prescaler #(.W(PRE_W)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .load   (load),
    .reload (pre_rld),
    .value  (pre_live),
    .step   (step)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_live <= CNT_ZERO;
    end else if (load) begin
      cnt_live <= cnt_rld;
    end else if (step) begin
      if (cnt_live != CNT_ZERO) cnt_live <= cnt_live - 1'b1;
      else if (periodic)        cnt_live <= cnt_rld;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      periodic <= 1'b0;
    end else if (ctl_we) begin
      en       <= ctl_wdata[CTL_EN];
      periodic <= ctl_wdata[CTL_PER];
    end else if (underflow && !periodic) begin
      en <= 1'b0;
    end
  end
endmodule

// File: rtl/dtu_irq_arb.sv
module dtu_irq_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_evt,
  input  logic lo_evt,
  output logic irq_hi,
  output logic irq_lo
);
  logic lo_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_hi  <= 1'b0;
      irq_lo  <= 1'b0;
      lo_pend <= 1'b0;
    end else begin
      irq_hi <= hi_evt;
      if (hi_evt) begin
        irq_lo  <= 1'b0;
        lo_pend <= lo_pend || lo_evt;
      end else begin
        irq_lo  <= lo_pend || lo_evt;
        lo_pend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dtu_top.sv
module dtu_top #(
  parameter int DATA_W    = 32,
  parameter int GPT_PRE_W = 16,
  parameter int RTC_PRE_W = 8,
  parameter int CNT_W     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [dtu_pkg::ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [dtu_pkg::ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       dbg_pin,
  output logic                       rtc_tick,
  output logic                       irq_rtc,
  output logic                       irq_gpt
);
  import dtu_pkg::*;

  logic [GPT_PRE_W-1:0] gpt_pre_rld, gpt_pre_live;
  logic [RTC_PRE_W-1:0] rtc_pre_rld, rtc_pre_live;
  logic [CNT_W-1:0]     gpt_cnt_rld, gpt_cnt_live;
  logic [CNT_W-1:0]     rtc_cnt_rld, rtc_cnt_live;
  logic                 sys_dbg_en;
  logic                 freeze;
  logic                 gpt_ctl_we, rtc_ctl_we;
  logic                 gpt_en, gpt_per, rtc_en, rtc_per;
  logic                 gpt_step, rtc_step, gpt_uf, rtc_uf;

  assign freeze     = sys_dbg_en && dbg_pin;
  assign gpt_ctl_we = wr_en && (wr_addr == A_GPT_CTL);
  assign rtc_ctl_we = wr_en && (wr_addr == A_RTC_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpt_pre_rld <= '0;
      gpt_cnt_rld <= '0;
      rtc_pre_rld <= '0;
      rtc_cnt_rld <= '0;
      sys_dbg_en  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_GPT_PRE: gpt_pre_rld <= wr_data[GPT_PRE_W-1:0];
        A_GPT_CNT: gpt_cnt_rld <= wr_data[CNT_W-1:0];
        A_RTC_PRE: rtc_pre_rld <= wr_data[RTC_PRE_W-1:0];
        A_RTC_CNT: rtc_cnt_rld <= wr_data[CNT_W-1:0];
        A_SYS_CTL: sys_dbg_en  <= wr_data[0];
        default:   ;
      endcase
    end
  end

  dtu_channel #(.PRE_W(GPT_PRE_W), .CNT_W(CNT_W)) u_gpt (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .ctl_we    (gpt_ctl_we),
    .ctl_wdata (wr_data[CTL_W-1:0]),
    .pre_rld   (gpt_pre_rld),
    .cnt_rld   (gpt_cnt_rld),
    .en        (gpt_en),
    .periodic  (gpt_per),
    .pre_live  (gpt_pre_live),
    .cnt_live  (gpt_cnt_live),
    .step      (gpt_step),
    .underflow (gpt_uf)
  );

  dtu_channel #(.PRE_W(RTC_PRE_W), .CNT_W(CNT_W)) u_rtc (
    .clk       (clk),
    .rst_n     (rst_n),
    .freeze    (freeze),
    .ctl_we    (rtc_ctl_we),
    .ctl_wdata (wr_data[CTL_W-1:0]),
    .pre_rld   (rtc_pre_rld),
    .cnt_rld   (rtc_cnt_rld),
    .en        (rtc_en),
    .periodic  (rtc_per),
    .pre_live  (rtc_pre_live),
    .cnt_live  (rtc_cnt_live),
    .step      (rtc_step),
    .underflow (rtc_uf)
  );

  dtu_irq_arb u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .hi_evt (rtc_uf),
    .lo_evt (gpt_uf),
    .irq_hi (irq_rtc),
    .irq_lo (irq_gpt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rtc_tick <= 1'b0;
    else        rtc_tick <= rtc_step;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_GPT_PRE:  rd_data = DATA_W'(gpt_pre_rld);
      A_GPT_CNT:  rd_data = DATA_W'(gpt_cnt_rld);
      A_GPT_CTL:  rd_data = DATA_W'({gpt_per, gpt_en});
      A_RTC_PRE:  rd_data = DATA_W'(rtc_pre_rld);
      A_RTC_CNT:  rd_data = DATA_W'(rtc_cnt_rld);
      A_RTC_CTL:  rd_data = DATA_W'({rtc_per, rtc_en});
      A_SYS_CTL:  rd_data = DATA_W'(sys_dbg_en);
      A_GPT_PLIV: rd_data = DATA_W'(gpt_pre_live);
      A_GPT_CLIV: rd_data = DATA_W'(gpt_cnt_live);
      A_RTC_PLIV: rd_data = DATA_W'(rtc_pre_live);
      A_RTC_CLIV: rd_data = DATA_W'(rtc_cnt_live);
      default:    rd_data = '0;
    endcase
  end
endmodule

// File: rtl/dtu_chk.sv
module dtu_chk #(
  parameter int GPT_PRE_W = 16,
  parameter int RTC_PRE_W = 8,
  parameter int CNT_W     = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 freeze,
  input logic [GPT_PRE_W-1:0] gpt_pre_live,
  input logic [CNT_W-1:0]     gpt_cnt_live,
  input logic [RTC_PRE_W-1:0] rtc_pre_live,
  input logic [CNT_W-1:0]     rtc_cnt_live,
  input logic [CNT_W-1:0]     gpt_cnt_rld,
  input logic                 gpt_ctl_we,
  input logic                 gpt_en,
  input logic                 gpt_per,
  input logic                 rtc_en,
  input logic                 gpt_step,
  input logic                 rtc_step,
  input logic                 gpt_uf,
  input logic                 rtc_uf,
  input logic                 rtc_tick,
  input logic                 irq_rtc,
  input logic                 irq_gpt
);
  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> ($stable(gpt_pre_live) && $stable(gpt_cnt_live) &&
                            $stable(rtc_pre_live) && $stable(rtc_cnt_live)));

  // R9
  freeze_nostep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> (!gpt_step && !rtc_step));

  // R5
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpt_uf && !gpt_per && !gpt_ctl_we) |=> !gpt_en);

  // R4
  periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gpt_uf && gpt_per && !gpt_ctl_we) |=> (gpt_cnt_live == $past(gpt_cnt_rld)));

  // R8
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({irq_rtc, irq_gpt}));

  // R8
  gpt_defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_uf && gpt_uf) |=> (irq_rtc && !irq_gpt));

  // R7
  rtc_irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rtc |-> $past(rtc_uf));

  // R10
  tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_tick |-> $past(rtc_en));
endmodule

bind dtu_top dtu_chk #(
  .GPT_PRE_W (GPT_PRE_W),
  .RTC_PRE_W (RTC_PRE_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .freeze       (freeze),
  .gpt_pre_live (gpt_pre_live),
  .gpt_cnt_live (gpt_cnt_live),
  .rtc_pre_live (rtc_pre_live),
  .rtc_cnt_live (rtc_cnt_live),
  .gpt_cnt_rld  (gpt_cnt_rld),
  .gpt_ctl_we   (gpt_ctl_we),
  .gpt_en       (gpt_en),
  .gpt_per      (gpt_per),
  .rtc_en       (rtc_en),
  .gpt_step     (gpt_step),
  .rtc_step     (rtc_step),
  .gpt_uf       (gpt_uf),
  .rtc_uf       (rtc_uf),
  .rtc_tick     (rtc_tick),
  .irq_rtc      (irq_rtc),
  .irq_gpt      (irq_gpt)
);

// File: tb/dtu_top_tb.sv
`timescale 1ns/1ps
module dtu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        dbg_pin = 1'b0;
  logic        rtc_tick, irq_rtc, irq_gpt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int ticks  = 0;
  int q_gpt[$];
  int q_rtc[$];
  bit done = 1'b0;

  localparam logic [31:0] EN = 32'h1, PER = 32'h2, LD = 32'h4;

  always #4 clk = ~clk;

  dtu_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .dbg_pin(dbg_pin), .rtc_tick(rtc_tick), .irq_rtc(irq_rtc), .irq_gpt(irq_gpt)
  );

  always @(posedge clk) if (rst_n) cyc++;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected interrupt cycles and compares (R2 R4 R7 R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (rtc_tick) ticks++;
      if (irq_rtc && irq_gpt) check("R8 both lines high", 32'd1, 32'd0);
      if (irq_rtc) begin
        if (q_rtc.size() == 0) check("R7 unexpected irq_rtc", 32'(cyc), 32'hFFFF_FFFF);
        else check("R2 irq_rtc cycle", 32'(cyc), 32'(q_rtc.pop_front()));
      end
      if (irq_gpt) begin
        if (q_gpt.size() == 0) check("R7 unexpected irq_gpt", 32'(cyc), 32'hFFFF_FFFF);
        else check("R2 irq_gpt cycle", 32'(cyc), 32'(q_gpt.pop_front()));
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq_gpt", 32'(irq_gpt), 0);
    check("R1 irq_rtc", 32'(irq_rtc), 0);
    check("R1 rtc_tick", 32'(rtc_tick), 0);
    for (int a = 0; a < 12; a++) begin
      rd(4'(a), d);
      check("R1 register reset", d, 0);
    end

    // R3 prescaler widths
    wr(4'd3, 32'h1FF); rd(4'd3, d); check("R3 rtc prescaler 8 bit", d, 32'hFF);
    wr(4'd0, 32'h12345); rd(4'd0, d); check("R3 gpt prescaler 16 bit", d, 32'h2345);

    // R2 R7 R5 one-shot GPT: P=2 C=3 -> 12
    wr(4'd0, 2); wr(4'd1, 3);
    wr(4'd2, LD | EN); l = cyc; q_gpt.push_back(l + 12);
    wait_until(l + 20);
    rd(4'd2, d); check("R5 one-shot enable cleared", d & 32'h1, 0);
    wait_until(l + 50);
    check("R2 gpt irq delivered", 32'(q_gpt.size()), 0);

    // R4 periodic GPT: P=1 C=2 -> 6
    wr(4'd0, 1); wr(4'd1, 2);
    wr(4'd2, LD | EN | PER); l = cyc;
    q_gpt.push_back(l + 6); q_gpt.push_back(l + 12); q_gpt.push_back(l + 18);
    wait_until(l + 19);
    wr(4'd2, 0);
    wait_until(l + 40);
    check("R4 periodic irqs delivered", 32'(q_gpt.size()), 0);

    // R9 freeze for 5 clocks: P=3 C=1 -> 8, shifted to 13
    wr(4'd6, 1);
    wr(4'd0, 3); wr(4'd1, 1);
    wr(4'd2, LD | EN); l = cyc; q_gpt.push_back(l + 13);
    wait_until(l + 2);
    dbg_pin = 1'b1;
    repeat (5) @(negedge clk);
    dbg_pin = 1'b0;
    wait_until(l + 30);
    check("R9 frozen delay", 32'(q_gpt.size()), 0);

    // R9 pin alone does not freeze; RTC P=0 C=4 -> 5
    wr(4'd6, 0);
    dbg_pin = 1'b1;
    wr(4'd3, 0); wr(4'd4, 4);
    wr(4'd5, LD | EN); l = cyc; q_rtc.push_back(l + 5);
    wait_until(l + 15);
    dbg_pin = 1'b0;
    check("R9 no freeze without allow bit", 32'(q_rtc.size()), 0);

    // R6 load under freeze, live readback; R8 collision; R10 ticks
    wr(4'd6, 1);
    dbg_pin = 1'b1;
    wr(4'd0, 5); wr(4'd1, 7); wr(4'd2, LD | EN);
    wr(4'd3, 5); wr(4'd4, 7); wr(4'd5, LD | EN);
    rd(4'd8, d);  check("R6 gpt live prescaler", d, 5);
    rd(4'd9, d);  check("R6 gpt live counter", d, 7);
    rd(4'd10, d); check("R6 rtc live prescaler", d, 5);
    rd(4'd11, d); check("R6 rtc live counter", d, 7);
    rd(4'd2, d);  check("R6 gpt enabled", d, 1);
    @(negedge clk);
    ticks = 0;
    l = cyc;
    dbg_pin = 1'b0;
    q_rtc.push_back(l + 48);
    q_gpt.push_back(l + 49);
    wait_until(l + 70);
    check("R8 rtc first gpt next", 32'(q_rtc.size() + q_gpt.size()), 0);
    check("R10 rtc tick count", 32'(ticks), 8);
    rd(4'd5, d); check("R5 rtc one-shot cleared", d, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule